// File: doc/BRIEF.md
# Region Freeze Controller

This block sits between a system register bus and a logic region that can be reconfigured while the rest of the chip keeps running. Software writes a control word to ask for the region to be frozen, to hold the region in reset while it is frozen, or to release it again. The block drives a freeze line and a reset line into the region. It reports through a status word when each transition has finished.

A freeze completes when the region signals that its outstanding traffic has drained, or when a fixed drain count runs out, whichever comes first. An unfreeze first releases reset and then drops freeze on the next cycle. A request that does not fit the current state is ignored and recorded in a sticky flag word, which software clears by writing ones. A constant identification word can be read at any time.

Register word offsets are fixed: status at 0x0, control at 0x4, flags at 0x8 and identification at 0xC. Reads are combinational while the read strobe is high.

Top module: `freeze_ctl`

## Requirements
- R1: After reset, status reads 0x2, the control and flag words read 0, and both region outputs are low.
- R2: Offset 0xC always reads 0xAD000003, and writes to it have no effect.
- R3: Writing control bit 0 while unfrozen raises region_freeze on the next cycle, and status reads 0 until the freeze completes.
- R4: While freezing, drain_ack high at a clock edge makes status read 0x1 (bit 0 = frozen) after that edge.
- R5: With drain_ack low, status reads 0x1 after DRAIN_CYCLES clock edges in the freezing state.
- R6: Writing control bit 1 while frozen drives region_reset high and holds it while frozen; writing 0 to control releases it.
- R7: Writing control bit 2 while frozen lowers region_reset on the next cycle with region_freeze still high, lowers region_freeze one cycle later, and status reads 0x2 (bit 1 = unfrozen) one cycle after that; status reads 0 in between.
- R8: A control write is ignored as a whole if it carries an illegal request. It sets flag bit 0 for a freeze while not unfrozen, bit 1 for an unfreeze while not frozen, and bit 2 for a reset while not frozen.
- R9: Flag bits stay set until written with a 1 at offset 0x8; writing 0 to a bit leaves it unchanged.
- R10: Control reads back the last accepted request bits. Writing 0 withdraws them but does not abort a freeze already in progress.
- R11: rdata is 0 whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| drain_ack | input | 1 | Region reports that its traffic has drained |
| region_freeze | output | 1 | Isolates the region |
| region_reset | output | 1 | Holds the region in reset |

## Verification
A sequencer that sits in the wrong state shows up at once in the status word, because the status bits decode the state directly. It also shows up within one cycle on the freeze and reset lines. A legality mistake appears on the next read of the flag word. It also appears as a control write that moves the region when it should not, and this is visible the cycle after the write. Errors in drain timing appear as a completion that comes one edge early or one edge late. The bench therefore samples status on each edge near the drain limit and the drain acknowledge.

// File: rtl/freeze_ctl.sv
module freeze_ctl #(
  parameter int          ADDR_W       = 4,
  parameter int          DRAIN_CYCLES = 256,
  parameter logic [31:0] VERSION      = 32'hAD000003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              drain_ack,
  output logic              region_freeze,
  output logic              region_reset
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int CNT_W  = $clog2(DRAIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRAIN_CYCLES - 1);

  typedef enum logic [2:0] {ST_RUN, ST_FREEZING, ST_FROZEN, ST_DROP_RST, ST_DROP_FRZ} st_t;

  st_t              st;
  logic [CNT_W-1:0] drain_cnt;
  logic [2:0]       ctrl_q;
  logic [2:0]       flags;

  wire [WORD_W-1:0] word = addr[ADDR_W-1:2];
  wire ctrl_wr = wr_en && word == WORD_W'(1);
  wire flag_wr = wr_en && word == WORD_W'(2);

  wire sts_run    = st == ST_RUN;
  wire sts_frozen = st == ST_FROZEN;

  wire [2:0] bad = {wdata[1] && !sts_frozen, wdata[2] && !sts_frozen, wdata[0] && !sts_run};
  wire ctrl_ok   = ctrl_wr && bad == 3'b000;
  wire [2:0] clr_mask = flag_wr ? wdata[2:0] : 3'b000;
  wire drain_done = drain_ack || drain_cnt == CNT_LAST;

  wire unused_ok = &{1'b0, wdata[31:3], addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_RUN;
    end else begin
      case (st)
        ST_RUN:      if (ctrl_ok && wdata[0]) st <= ST_FREEZING;
        ST_FREEZING: if (drain_done) st <= ST_FROZEN;
        ST_FROZEN:   if (ctrl_ok && wdata[2]) st <= ST_DROP_RST;
        ST_DROP_RST: st <= ST_DROP_FRZ;
        default:     st <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st != ST_FREEZING) drain_cnt <= '0;
    else                             drain_cnt <= drain_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= 3'b000;
    else if (ctrl_ok) ctrl_q <= {wdata[2], wdata[1] & ~wdata[2], wdata[0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= 3'b000;
    else        flags <= (flags & ~clr_mask) | (ctrl_wr ? bad : 3'b000);
  end

  assign region_freeze = st == ST_FREEZING || st == ST_FROZEN || st == ST_DROP_RST;
  assign region_reset  = sts_frozen && ctrl_q[1];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (word)
        WORD_W'(0): rdata = {30'b0, sts_run, sts_frozen};
        WORD_W'(1): rdata = {29'b0, ctrl_q};
        WORD_W'(2): rdata = {29'b0, flags};
        WORD_W'(3): rdata = VERSION;
        default:    rdata = '0;
      endcase
    end
  end

  // R3
  freeze_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_ok && wdata[0] && sts_run) |=> (region_freeze && !sts_run && !sts_frozen));

  // R4
  drain_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FREEZING && drain_ack) |=> sts_frozen);

  // R5
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FREEZING) |-> (drain_cnt <= CNT_LAST));

  // R6
  reset_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region_reset |-> region_freeze);

  // R7
  thaw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(region_freeze) |-> (!region_reset && !$past(region_reset)));

  // R8
  ignored_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bad != 3'b000 && sts_frozen) |=> (sts_frozen && $stable(ctrl_q)));

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~clr_mask) != 3'b000) |=>
      ((flags & $past(flags & ~clr_mask)) == $past(flags & ~clr_mask)));
endmodule

// File: tb/freeze_ctl_test.sv
module freeze_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DRAIN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        drain_ack = 1'b0;
  logic        region_freeze;
  logic        region_reset;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  freeze_ctl #(.ADDR_W(4), .DRAIN_CYCLES(DRAIN)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .drain_ack(drain_ack),
    .region_freeze(region_freeze), .region_reset(region_reset));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } step_t;

  localparam int NSTEP = 28;
  localparam step_t STEPS [NSTEP] = '{
    '{2'd0, 4'd12, 32'h0,        32'hAD000003, 4'd2},  // R2
    '{2'd1, 4'd12, 32'hFFFFFFFF, 32'h0,        4'd2},  // R2
    '{2'd0, 4'd12, 32'h0,        32'hAD000003, 4'd2},  // R2
    '{2'd0, 4'd0,  32'h0,        32'h2,        4'd1},  // R1
    '{2'd1, 4'd4,  32'h4,        32'h0,        4'd8},  // R8
    '{2'd0, 4'd8,  32'h0,        32'h2,        4'd8},  // R8
    '{2'd0, 4'd0,  32'h0,        32'h2,        4'd8},  // R8
    '{2'd0, 4'd4,  32'h0,        32'h0,        4'd10}, // R10
    '{2'd1, 4'd4,  32'h2,        32'h0,        4'd8},  // R8
    '{2'd0, 4'd8,  32'h0,        32'h6,        4'd8},  // R8
    '{2'd1, 4'd8,  32'h2,        32'h0,        4'd9},  // R9
    '{2'd0, 4'd8,  32'h0,        32'h4,        4'd9},  // R9
    '{2'd1, 4'd8,  32'hFFFFFFF8, 32'h0,        4'd9},  // R9
    '{2'd0, 4'd8,  32'h0,        32'h4,        4'd9},  // R9
    '{2'd1, 4'd8,  32'h4,        32'h0,        4'd9},  // R9
    '{2'd0, 4'd8,  32'h0,        32'h0,        4'd9},  // R9
    '{2'd1, 4'd4,  32'h1,        32'h0,        4'd3},  // R3
    '{2'd0, 4'd0,  32'h0,        32'h0,        4'd3},  // R3
    '{2'd0, 4'd4,  32'h0,        32'h1,        4'd10}, // R10
    '{2'd2, 4'd0,  32'd3,        32'h0,        4'd5},  // R5
    '{2'd0, 4'd0,  32'h0,        32'h0,        4'd5},  // R5
    '{2'd2, 4'd0,  32'd1,        32'h0,        4'd5},  // R5
    '{2'd0, 4'd0,  32'h0,        32'h1,        4'd5},  // R5
    '{2'd1, 4'd4,  32'h1,        32'h0,        4'd8},  // R8
    '{2'd0, 4'd8,  32'h0,        32'h1,        4'd8},  // R8
    '{2'd0, 4'd0,  32'h0,        32'h1,        4'd8},  // R8
    '{2'd1, 4'd8,  32'h1,        32'h0,        4'd9},  // R9
    '{2'd0, 4'd8,  32'h0,        32'h0,        4'd9}   // R9
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1 reset state
    expect_reg("R1 status", 4'd0, 32'h2);
    expect_reg("R1 control", 4'd4, 32'h0);
    expect_reg("R1 flags", 4'd8, 32'h0);
    check("R1 freeze", {31'b0, region_freeze}, 32'h0);
    check("R1 reset", {31'b0, region_reset}, 32'h0);

    for (int i = 0; i < NSTEP; i++) begin
      logic [31:0] v;
      case (STEPS[i].op)
        2'd0: begin
          rd(STEPS[i].a, v);
          check($sformatf("R%0d step %0d", STEPS[i].r, i), v, STEPS[i].e);
        end
        2'd1: wr(STEPS[i].a, STEPS[i].d);
        default: tick(int'(STEPS[i].d));
      endcase
    end

    // R3 frozen outputs
    check("R3 freeze held", {31'b0, region_freeze}, 32'h1);
    check("R3 no reset", {31'b0, region_reset}, 32'h0);

    // R6 reset request and hold
    wr(4'd4, 32'h2);
    check("R6 reset on", {31'b0, region_reset}, 32'h1);
    expect_reg("R6 control", 4'd4, 32'h2);
    tick(3);
    check("R6 reset held", {31'b0, region_reset}, 32'h1);
    // R8 illegal freeze while frozen leaves reset alone
    wr(4'd4, 32'h1);
    check("R8 reset kept", {31'b0, region_reset}, 32'h1);
    expect_reg("R8 flag0", 4'd8, 32'h1);
    wr(4'd8, 32'h1);
    wr(4'd4, 32'h0);
    check("R6 reset released", {31'b0, region_reset}, 32'h0);
    check("R6 still frozen", {31'b0, region_freeze}, 32'h1);
    expect_reg("R6 status", 4'd0, 32'h1);

    // R7 ordered release
    wr(4'd4, 32'h2);
    wr(4'd4, 32'h4);
    check("R7 reset low first", {31'b0, region_reset}, 32'h0);
    check("R7 freeze still high", {31'b0, region_freeze}, 32'h1);
    expect_reg("R7 status mid1", 4'd0, 32'h0);
    tick(1);
    check("R7 freeze low", {31'b0, region_freeze}, 32'h0);
    expect_reg("R7 status mid2", 4'd0, 32'h0);
    tick(1);
    expect_reg("R7 status done", 4'd0, 32'h2);

    // R4 drain acknowledge ends the freeze early
    drain_ack = 1'b1;
    wr(4'd4, 32'h1);
    check("R4 freeze high", {31'b0, region_freeze}, 32'h1);
    expect_reg("R4 status busy", 4'd0, 32'h0);
    tick(1);
    expect_reg("R4 status frozen", 4'd0, 32'h1);
    drain_ack = 1'b0;

    // R8 request during a transition
    wr(4'd4, 32'h4);
    wr(4'd4, 32'h1);
    expect_reg("R8 flag during thaw", 4'd8, 32'h1);
    expect_reg("R8 status mid", 4'd0, 32'h0);
    tick(1);
    expect_reg("R8 thaw completes", 4'd0, 32'h2);
    wr(4'd8, 32'h1);

    // R10 withdrawal does not abort a freeze
    wr(4'd4, 32'h1);
    wr(4'd4, 32'h0);
    expect_reg("R10 control cleared", 4'd4, 32'h0);
    check("R10 freeze kept", {31'b0, region_freeze}, 32'h1);
    tick(2);
    expect_reg("R10 status busy", 4'd0, 32'h0);
    tick(1);
    expect_reg("R10 status frozen", 4'd0, 32'h1);

    // R11 no read strobe
    addr = 4'd12; rd_en = 1'b0;
    #1 check("R11 idle rdata", rdata, 32'h0);

    // R1 reset from a frozen, flagged state
    wr(4'd4, 32'h1);
    rst_n = 1'b0;
    tick(1);
    rst_n = 1'b1;
    expect_reg("R1 status again", 4'd0, 32'h2);
    expect_reg("R1 flags again", 4'd8, 32'h0);
    expect_reg("R1 control again", 4'd4, 32'h0);
    check("R1 freeze again", {31'b0, region_freeze}, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule